// File: doc/BRIEF.md
# Host Byte-Bus Register Slave

This block is the instrument side of a slow, asynchronous 8-bit parallel bus driven by a host processor. The host places a 4-bit address and write data on the bus and pulses an active-high read or write strobe. Each strobe is at least 250 ns wide. Address and write data stay valid for 250 ns on either side of the strobe's trailing edge. The block brings both strobes into its local clock domain through a three-stage shift register. It acts only when a synchronised strobe falls.

The register set holds two 24-bit range-gate limits, each written one byte at a time. It also holds three 8-bit mode words, a read-only 8-bit counter of science bytes transferred, and a science-data read port. A write to one dedicated address is a software reset. Read data is a combinational selection by address, so it is valid well inside the required window around the read strobe's trailing edge. An odd-parity bit is driven with the read data.

Status word 2 carries a cycle-slip flag in bit 0. The flag is raised when the host reads science data that the source has not yet refreshed, or when the source reports a lost byte. The host clears it by writing a 1 to that bit.

Top module: `hostbus_regs`

## Requirements
- R1: Range-gate start bytes sit at addresses 1 (bits 7:0), 2 (15:8) and 3 (23:16), and range-gate end bytes sit at 5, 6 and 7 in the same byte order. A written byte reads back unchanged and appears on the matching `gate_start` or `gate_end` output.
- R2: Mode word 1 (address 8) and mode word 3 (address 11) read back all 8 bits as written. Mode word 2 (address 9) stores bits 7:1 and reads them back, and bit 0 of its read value is the cycle-slip flag.
- R3: On every read, `bus_rpar` makes the 9 bits {`bus_rpar`, `bus_rdata`} hold an odd number of ones.
- R4: Addresses 4, 13, 14 and 15 read 0x00. Writes to them, and to the read-only addresses 0 and 10, change no register.
- R5: A write commits only after its synchronised strobe has fallen. While the write strobe is still high, the addressed register keeps its old value.
- R6: A read of address 0 returns `sci_byte`. Each such read gives exactly one single-cycle `sci_take` pulse, issued after the read strobe's trailing edge.
- R7: Address 10 returns the number of science reads since the last reset, modulo 256. The value after 256 reads is 0x00.
- R8: The cycle-slip flag sets when a science read completes while `sci_valid` is low, or when `sci_lost` is high.
- R9: A write to address 9 with bit 0 set clears the cycle-slip flag. If a set condition falls in the same cycle as that clear, the flag ends set.
- R10: A write of any value to address 12 restores every mode and range-gate register to its power-on default, clears the transfer counter and clears the cycle-slip flag.
- R11: After reset, mode word 1 reads 0x04 (rate select 10 in bits 2:1, real data, byte transfers), and mode word 2 reads 0x00 (pulse-per-second inhibited, no slip). Mode word 3 reads 0x00, the counter reads 0x00, and the range gates hold the parameter defaults (start 0x000100, end 0x00FFFF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address from host |
| bus_wdata | input | 8 | Write data from host |
| bus_rd | input | 1 | Read strobe, active high, asynchronous |
| bus_wr | input | 1 | Write strobe, active high, asynchronous |
| bus_rdata | output | 8 | Read data to host |
| bus_rpar | output | 1 | Odd parity over bus_rdata |
| sci_byte | input | 8 | Current science byte from the data source |
| sci_valid | input | 1 | Source holds a fresh, unread byte |
| sci_lost | input | 1 | Source reports a dropped byte (one-cycle pulse) |
| sci_take | output | 1 | Advance pulse to the data source |
| gate_start | output | 24 | Range-gate start limit |
| gate_end | output | 24 | Range-gate end limit |
| mode1 | output | 8 | Mode word 1 |
| mode2 | output | 8 | Mode word 2, bit 0 being the cycle-slip flag |
| mode3 | output | 8 | Mode word 3 |

## Verification
The cycle-slip flag can be set by a `sci_lost` pulse in the same clock cycle in which a write-one-to-clear to address 9 commits. The bench drops the write strobe on a falling clock edge and counts the two synchroniser edges that follow. It then drives `sci_lost` for exactly the one cycle that spans the commit edge. It judges the result by reading address 9 afterwards and expecting bit 0 to be 1. A lower-priority set or a plain register write would give 0 there. A separate science read with `sci_valid` low checks the other set path against a later clear.

// File: rtl/hostbus_regs.sv
module hostbus_regs #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int GATE_W = 24,
  parameter int CNT_W = 8,
  parameter logic [GATE_W-1:0] GATE_START_DEF = 24'h000100,
  parameter logic [GATE_W-1:0] GATE_END_DEF = 24'h00FFFF,
  parameter logic [DW-1:0] MODE1_DEF = 8'h04,
  parameter logic [DW-1:0] MODE2_DEF = 8'h00,
  parameter logic [DW-1:0] MODE3_DEF = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rpar,
  input  logic [DW-1:0]     sci_byte,
  input  logic              sci_valid,
  input  logic              sci_lost,
  output logic              sci_take,
  output logic [GATE_W-1:0] gate_start,
  output logic [GATE_W-1:0] gate_end,
  output logic [DW-1:0]     mode1,
  output logic [DW-1:0]     mode2,
  output logic [DW-1:0]     mode3
);
  localparam logic [AW-1:0] A_SCI   = AW'(0);
  localparam logic [AW-1:0] A_GS0   = AW'(1);
  localparam logic [AW-1:0] A_GS1   = AW'(2);
  localparam logic [AW-1:0] A_GS2   = AW'(3);
  localparam logic [AW-1:0] A_GE0   = AW'(5);
  localparam logic [AW-1:0] A_GE1   = AW'(6);
  localparam logic [AW-1:0] A_GE2   = AW'(7);
  localparam logic [AW-1:0] A_M1    = AW'(8);
  localparam logic [AW-1:0] A_M2    = AW'(9);
  localparam logic [AW-1:0] A_CNT   = AW'(10);
  localparam logic [AW-1:0] A_M3    = AW'(11);
  localparam logic [AW-1:0] A_SWRST = AW'(12);

  logic [2:0] wr_sy, rd_sy;
  logic wr_fall, rd_fall, sw_rst;
  logic [GATE_W-1:0] gs_q, ge_q;
  logic [DW-1:0] m1_q, m3_q;
  logic [DW-1:1] m2_q;
  logic slip;
  logic [CNT_W-1:0] xfer_cnt;
  logic slip_set, slip_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sy <= '0;
      rd_sy <= '0;
    end else begin
      wr_sy <= {wr_sy[1:0], bus_wr};
      rd_sy <= {rd_sy[1:0], bus_rd};
    end
  end

  assign wr_fall  = wr_sy[2] & ~wr_sy[1];
  assign rd_fall  = rd_sy[2] & ~rd_sy[1];
  assign sw_rst   = wr_fall && (bus_addr == A_SWRST);
  assign sci_take = rd_fall && (bus_addr == A_SCI);
  assign slip_set = (sci_take && !sci_valid) || sci_lost;
  assign slip_clr = wr_fall && (bus_addr == A_M2) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gs_q     <= GATE_START_DEF;
      ge_q     <= GATE_END_DEF;
      m1_q     <= MODE1_DEF;
      m2_q     <= MODE2_DEF[DW-1:1];
      m3_q     <= MODE3_DEF;
      slip     <= 1'b0;
      xfer_cnt <= '0;
    end else if (sw_rst) begin
      gs_q     <= GATE_START_DEF;
      ge_q     <= GATE_END_DEF;
      m1_q     <= MODE1_DEF;
      m2_q     <= MODE2_DEF[DW-1:1];
      m3_q     <= MODE3_DEF;
      slip     <= 1'b0;
      xfer_cnt <= '0;
    end else begin
      if (wr_fall) begin
        case (bus_addr)
          A_GS0:   gs_q[7:0]   <= bus_wdata;
          A_GS1:   gs_q[15:8]  <= bus_wdata;
          A_GS2:   gs_q[23:16] <= bus_wdata;
          A_GE0:   ge_q[7:0]   <= bus_wdata;
          A_GE1:   ge_q[15:8]  <= bus_wdata;
          A_GE2:   ge_q[23:16] <= bus_wdata;
          A_M1:    m1_q        <= bus_wdata;
          A_M2:    m2_q        <= bus_wdata[DW-1:1];
          A_M3:    m3_q        <= bus_wdata;
          default: ;
        endcase
      end
      if (slip_set)      slip <= 1'b1;
      else if (slip_clr) slip <= 1'b0;
      if (sci_take) xfer_cnt <= xfer_cnt + 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_SCI:   bus_rdata = sci_byte;
      A_GS0:   bus_rdata = gs_q[7:0];
      A_GS1:   bus_rdata = gs_q[15:8];
      A_GS2:   bus_rdata = gs_q[23:16];
      A_GE0:   bus_rdata = ge_q[7:0];
      A_GE1:   bus_rdata = ge_q[15:8];
      A_GE2:   bus_rdata = ge_q[23:16];
      A_M1:    bus_rdata = m1_q;
      A_M2:    bus_rdata = {m2_q, slip};
      A_CNT:   bus_rdata = DW'(xfer_cnt);
      A_M3:    bus_rdata = m3_q;
      default: bus_rdata = '0;
    endcase
  end

  assign bus_rpar   = ~^bus_rdata;
  assign gate_start = gs_q;
  assign gate_end   = ge_q;
  assign mode1      = m1_q;
  assign mode2      = {m2_q, slip};
  assign mode3      = m3_q;
endmodule

// File: rtl/hostbus_regs_chk.sv
module hostbus_regs_chk #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int GATE_W = 24,
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_rdata,
  input logic              bus_rpar,
  input logic              sci_take,
  input logic              sci_lost,
  input logic              wr_fall,
  input logic [GATE_W-1:0] gate_start,
  input logic [CNT_W-1:0]  xfer_cnt,
  input logic              slip
);
  assert_odd_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({bus_rpar, bus_rdata}) % 2) == 1);

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(4) || bus_addr >= AW'(13)) |-> bus_rdata == '0);

  assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fall |=> $stable(gate_start));

  assert_take_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sci_take |=> !sci_take);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sci_take |=> xfer_cnt == CNT_W'($past(xfer_cnt) + 1'b1));

  assert_lost_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sci_lost |=> slip);
endmodule

bind hostbus_regs hostbus_regs_chk #(.AW(AW), .DW(DW), .GATE_W(GATE_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .bus_rpar(bus_rpar), .sci_take(sci_take), .sci_lost(sci_lost),
  .wr_fall(wr_fall), .gate_start(gate_start), .xfer_cnt(xfer_cnt), .slip(slip)
);

// File: tb/hostbus_regs_tb.sv
module hostbus_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic bus_rpar;
  logic [7:0] sci_byte = '0;
  logic sci_valid = 1'b1, sci_lost = 1'b0;
  logic sci_take;
  logic [23:0] gate_start, gate_end;
  logic [7:0] mode1, mode2, mode3;

  int errs = 0, checks = 0, takes = 0;
  bit done = 0;
  logic [7:0] rv;
  logic rp;

  always #2 clk = ~clk;

  hostbus_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_rpar(bus_rpar),
    .sci_byte(sci_byte), .sci_valid(sci_valid), .sci_lost(sci_lost), .sci_take(sci_take),
    .gate_start(gate_start), .gate_end(gate_end), .mode1(mode1), .mode2(mode2), .mode3(mode3)
  );

  always @(posedge clk) if (rst_n && sci_take) takes++;

  function automatic logic odd_bit(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(b[i]);
    return (n % 2 == 0);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    repeat (6) @(negedge clk);
    bus_wr = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_read(input logic [3:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    repeat (4) @(negedge clk);
    rv = bus_rdata; rp = bus_rpar;
    bus_rd = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    bus_read(a);
    chk(req, {24'd0, rv}, {24'd0, exp});
    chk("R3 parity", {31'd0, rp}, {31'd0, odd_bit(rv)});
  endtask

  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {4'd1, 8'h11, 8'h11}, {4'd2, 8'h22, 8'h22}, {4'd3, 8'h33, 8'h33},
    {4'd5, 8'h55, 8'h55}, {4'd6, 8'h66, 8'h66}, {4'd7, 8'h77, 8'h77},
    {4'd8, 8'hA9, 8'hA9}, {4'd11, 8'h3F, 8'h3F}, {4'd9, 8'hE3, 8'hE2},
    {4'd4, 8'hFF, 8'h00}, {4'd13, 8'h81, 8'h00}, {4'd14, 8'h7E, 8'h00},
    {4'd15, 8'hFF, 8'h00}, {4'd10, 8'h5A, 8'h00}
  };

  initial begin
    #800000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    read_chk("R11 mode1 default", 4'd8, 8'h04);
    read_chk("R11 mode2 default", 4'd9, 8'h00);
    read_chk("R11 mode3 default", 4'd11, 8'h00);
    read_chk("R11 counter default", 4'd10, 8'h00);
    chk("R11 gate_start default", {8'd0, gate_start}, 32'h000100);
    chk("R11 gate_end default", {8'd0, gate_end}, 32'h00FFFF);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] a;
      string req;
      a = VEC[i][19:16];
      if (a inside {4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd7}) req = "R1 gate readback";
      else if (a inside {4'd8, 4'd9, 4'd11}) req = "R2 mode readback";
      else req = "R4 reserved/read-only";
      bus_write(a, VEC[i][15:8]);
      read_chk(req, a, VEC[i][7:0]);
    end
    chk("R1 gate_start out", {8'd0, gate_start}, 32'h332211);
    chk("R1 gate_end out", {8'd0, gate_end}, 32'h776655);
    chk("R2 mode outs", {8'd0, mode1, mode2, mode3}, 32'h00A9E23F);

    // R5: register unchanged while write strobe still high
    @(negedge clk);
    bus_addr = 4'd1; bus_wdata = 8'hC4; bus_wr = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5 held during strobe", {24'd0, gate_start[7:0]}, 32'h11);
    bus_wr = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 commit after fall", {24'd0, gate_start[7:0]}, 32'hC4);

    // R6 science read and advance pulse
    sci_byte = 8'h3C; sci_valid = 1'b1; takes = 0;
    read_chk("R6 science byte", 4'd0, 8'h3C);
    chk("R6 one take pulse", takes, 1);
    sci_byte = 8'hB7;
    read_chk("R6 science byte 2", 4'd0, 8'hB7);
    chk("R6 two take pulses", takes, 2);
    read_chk("R7 count after 2", 4'd10, 8'h02);
    read_chk("R8 no slip when valid", 4'd9, 8'hE2);

    // R8 slip on stale read
    sci_valid = 1'b0;
    bus_read(4'd0);
    sci_valid = 1'b1;
    read_chk("R8 slip on stale read", 4'd9, 8'hE3);
    bus_write(4'd9, 8'hE3);
    read_chk("R9 clear by write one", 4'd9, 8'hE2);

    // R8 slip on lost pulse
    @(negedge clk); sci_lost = 1'b1;
    @(negedge clk); sci_lost = 1'b0;
    read_chk("R8 slip on lost", 4'd9, 8'hE3);
    bus_write(4'd9, 8'hE2);
    read_chk("R9 write zero keeps flag", 4'd9, 8'hE3);
    bus_write(4'd9, 8'hE3);
    read_chk("R9 cleared", 4'd9, 8'hE2);

    // R9 set and clear in same cycle
    @(negedge clk);
    bus_addr = 4'd9; bus_wdata = 8'hE3; bus_wr = 1'b1;
    repeat (6) @(negedge clk);
    bus_wr = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); sci_lost = 1'b1;
    @(negedge clk); sci_lost = 1'b0;
    repeat (4) @(negedge clk);
    read_chk("R9 set wins over clear", 4'd9, 8'hE3);

    // R7 wrap: count is 3 now, read up to 256 total
    for (int k = 3; k < 255; k++) bus_read(4'd0);
    read_chk("R7 count 255", 4'd10, 8'hFF);
    bus_read(4'd0);
    read_chk("R7 wrap to 0", 4'd10, 8'h00);

    // R10 software reset
    bus_write(4'd12, 8'h5A);
    read_chk("R10 mode1 restored", 4'd8, 8'h04);
    read_chk("R10 mode2 restored, slip cleared", 4'd9, 8'h00);
    read_chk("R10 mode3 restored", 4'd11, 8'h00);
    read_chk("R10 gate start low", 4'd1, 8'h00);
    read_chk("R10 gate start mid", 4'd2, 8'h01);
    chk("R10 gate_end restored", {8'd0, gate_end}, 32'h00FFFF);
    bus_read(4'd0);
    read_chk("R10 counter cleared then 1", 4'd10, 8'h01);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule